// File: doc/BRIEF.md
# Interrupt Vector Translation Latch

This block sits between the interrupt sources of a subsystem and a single CPU. A peripheral presents a request value on a 32-bit input; any non-zero value in a cycle is one request event. When translation is switched on, the value is looked up in a small table of key/vector pairs and the matching vector is latched as pending. When translation is off, the request value itself becomes the vector.

The pending vector is offered to the CPU every cycle, with a request line and the vector, until the CPU accepts it. Acceptance clears the pending register to zero, and a value of zero means nothing is pending. If a different vector arrives while one is still pending, a programmable policy decides the outcome. The error policy raises a sticky error flag. The replace policy lets the newer vector win. The fixed policy substitutes a programmed override vector.

The table and the control settings are written through a configuration port with one address space. Addresses below the table depth select a table entry. The address equal to the depth selects the control word.

Top module: `ivt_latch`

## Requirements
- R1: A request value of zero has no effect: the pending vector, the request line and the error state are unchanged by it.
- R2: With translation on, a non-zero request whose value equals the key of a non-empty table entry latches that entry's vector. When several entries carry the same key, the lowest-numbered entry wins.
- R3: With translation on, a non-zero request that matches no non-empty entry sets the error flag and leaves the pending vector unchanged.
- R4: With translation off, a non-zero request latches its own value as the vector.
- R5: A request whose resulting vector equals the vector already pending changes nothing and raises no error.
- R6: Under the error policy (policy code 0, and code 3, which behaves the same), a request with a different vector while one is pending sets the error flag and keeps the older vector.
- R7: Under the replace policy (policy code 1), a request with a different vector while one is pending replaces the pending vector with the new vector.
- R8: Under the fixed policy (policy code 2), a request with a different vector while one is pending stores the programmed override vector.
- R9: After synchronous reset nothing is pending, the error flag is clear, translation is off, the policy is the error policy and every table entry is empty.
- R10: While a vector is pending, the request line stays high and the vector stays stable until the CPU accepts it. With no new request, acceptance leaves nothing pending in the next cycle.
- R11: When a request and an acceptance occur in the same cycle, the request is handled as if nothing were pending, and its vector stays pending afterwards.
- R12: The error flag stays set until reset. The error value holds the request value of the first error and is not overwritten by later errors.
- R13: A configuration write to address n below the depth loads entry n with key cfg_key and vector cfg_vec. A key of zero empties the entry. A write to the address equal to the depth loads the control word: cfg_key bits 1:0 are the policy, cfg_key bit 2 is the translate enable, and cfg_vec is the override vector. All changes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Entry index, or the depth for the control word |
| cfg_key | input | 32 | Entry key, or the control bits |
| cfg_vec | input | 32 | Entry vector, or the override vector |
| req_value | input | 32 | Interrupt request value; zero means no request |
| irq_ack | input | 1 | CPU accepts the offered vector |
| irq_req | output | 1 | A vector is pending |
| irq_vec | output | 32 | Pending vector, zero when none |
| err_flag | output | 1 | Sticky error flag |
| err_val | output | 32 | Request value that caused the first error |

## Verification
The checker watches behaviour that is local in time on every cycle. It checks that zero requests leave the pending state alone, that an offer holds steady until it is accepted, that acceptance with no new request empties the register, that the error flag and its value are sticky, that reset clears state, and that an untranslated request lands as its own value. Table lookup with its priority among duplicate keys, the three conflict policies, the override vector, the same-vector case and the handling of a request and an acceptance in the same cycle all depend on programmed state and on a history of several cycles. Only the bench's scenarios show these.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int DEF_DW    = 32;
    localparam int DEF_DEPTH = 8;

    typedef enum logic [1:0] {
        POL_ERR     = 2'd0,
        POL_REPLACE = 2'd1,
        POL_FIXED   = 2'd2,
        POL_ERR_ALT = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_STORE = 2'd1,
        ACT_FLAG  = 2'd2
    } action_e;

    typedef struct packed {
        logic    xlat;
        policy_e pol;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{xlat: 1'b0, pol: POL_ERR};

    function automatic ctrl_t decode_ctrl(input logic [2:0] bits);
        ctrl_t c;
        c.xlat = bits[2];
        c.pol  = policy_e'(bits[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/ivt_table.sv
module ivt_table #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_key,
    input  logic [DW-1:0] wr_vec,
    input  logic [DW-1:0] look_key,
    output logic          hit,
    output logic [DW-1:0] hit_vec
);

    logic [DEPTH-1:0] ent_used;
    logic [DW-1:0]    ent_key [DEPTH];
    logic [DW-1:0]    ent_vec [DEPTH];
    logic [DEPTH-1:0] ent_match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_used[g] <= 1'b0;
                ent_key[g]  <= '0;
                ent_vec[g]  <= '0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                ent_used[g] <= (wr_key != '0);
                ent_key[g]  <= wr_key;
                ent_vec[g]  <= wr_vec;
            end
        end
        assign ent_match[g] = ent_used[g] && (ent_key[g] == look_key);
    end

    // lowest index has priority: scan downward so it is assigned last
    always_comb begin
        hit     = 1'b0;
        hit_vec = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent_match[i]) begin
                hit     = 1'b1;
                hit_vec = ent_vec[i];
            end
        end
    end

endmodule

// File: rtl/ivt_resolve.sv
module ivt_resolve
    import ivt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          [DW-1:0] req_value,
    input  ctrl_t                  ctrl,
    input  logic          [DW-1:0] ovr_vec,
    input  logic                   hit,
    input  logic          [DW-1:0] hit_vec,
    input  logic          [DW-1:0] pend_vec,
    input  logic                   pend_live,
    output action_e                act,
    output logic          [DW-1:0] new_vec
);

    logic [DW-1:0] cand;
    logic          cand_ok;

    always_comb begin
        cand    = ctrl.xlat ? hit_vec : req_value;
        cand_ok = !ctrl.xlat || hit;
    end

    always_comb begin
        act     = ACT_NONE;
        new_vec = cand;
        if (req_value != '0) begin
            if (!cand_ok) begin
                act = ACT_FLAG;
            end else if (!pend_live) begin
                act = ACT_STORE;
            end else if (cand != pend_vec) begin
                unique case (ctrl.pol)
                    POL_REPLACE: act = ACT_STORE;
                    POL_FIXED: begin
                        act     = ACT_STORE;
                        new_vec = ovr_vec;
                    end
                    default: act = ACT_FLAG;
                endcase
            end
        end
    end

endmodule

// File: rtl/ivt_state.sv
module ivt_state
    import ivt_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  action_e          act,
    input  logic    [DW-1:0] new_vec,
    input  logic    [DW-1:0] req_value,
    input  logic             ack,
    output logic    [DW-1:0] pend_vec,
    output logic             err_flag,
    output logic    [DW-1:0] err_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vec <= '0;
        end else if (act == ACT_STORE) begin
            pend_vec <= new_vec;
        end else if (ack) begin
            pend_vec <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
            err_val  <= '0;
        end else if ((act == ACT_FLAG) && !err_flag) begin
            err_flag <= 1'b1;
            err_val  <= req_value;
        end
    end

endmodule

// File: rtl/ivt_latch.sv
module ivt_latch
    import ivt_pkg::*;
#(
    parameter int DW    = DEF_DW,
    parameter int DEPTH = DEF_DEPTH,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int AW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_key,
    input  logic [DW-1:0] cfg_vec,
    input  logic [DW-1:0] req_value,
    input  logic          irq_ack,
    output logic          irq_req,
    output logic [DW-1:0] irq_vec,
    output logic          err_flag,
    output logic [DW-1:0] err_val
);

    ctrl_t         ctl_q;
    logic [DW-1:0] ovr_q;
    logic          tbl_we;
    logic          ctl_we;
    logic          hit;
    logic [DW-1:0] hit_vec;
    logic [DW-1:0] pend_vec;
    logic          pend_live;
    action_e       act;
    logic [DW-1:0] new_vec;

    assign tbl_we = cfg_we && (cfg_addr < AW'(DEPTH));
    assign ctl_we = cfg_we && (cfg_addr == AW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTRL_RESET;
            ovr_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= decode_ctrl(cfg_key[2:0]);
            ovr_q <= cfg_vec;
        end
    end

    ivt_table #(.DW(DW), .DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_idx  (cfg_addr[IW-1:0]),
        .wr_key  (cfg_key),
        .wr_vec  (cfg_vec),
        .look_key(req_value),
        .hit     (hit),
        .hit_vec (hit_vec)
    );

    // an offer accepted in this cycle no longer counts as pending
    assign pend_live = (pend_vec != '0) && !irq_ack;

    ivt_resolve #(.DW(DW)) u_resolve (
        .req_value(req_value),
        .ctrl     (ctl_q),
        .ovr_vec  (ovr_q),
        .hit      (hit),
        .hit_vec  (hit_vec),
        .pend_vec (pend_vec),
        .pend_live(pend_live),
        .act      (act),
        .new_vec  (new_vec)
    );

    ivt_state #(.DW(DW)) u_state (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .new_vec  (new_vec),
        .req_value(req_value),
        .ack      (irq_ack),
        .pend_vec (pend_vec),
        .err_flag (err_flag),
        .err_val  (err_val)
    );

    assign irq_req = (pend_vec != '0);
    assign irq_vec = pend_vec;

endmodule

// File: rtl/ivt_latch_chk.sv
module ivt_latch_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          xlat,
    input logic [DW-1:0] req_value,
    input logic          irq_ack,
    input logic          irq_req,
    input logic [DW-1:0] irq_vec,
    input logic          err_flag,
    input logic [DW-1:0] err_val
);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!irq_req && !err_flag));

    // R1
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((req_value == '0) && !irq_ack) |=> $stable(irq_vec));

    // R10
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_ack && (req_value == '0)) |=> (irq_req && $stable(irq_vec)));

    // R10
    accept_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && (req_value == '0)) |=> !irq_req);

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> (err_flag && $stable(err_val)));

    // R4
    raw_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (!xlat && (req_value != '0) && !irq_req) |=> (irq_vec == $past(req_value)));

endmodule

bind ivt_latch ivt_latch_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .xlat     (ctl_q.xlat),
    .req_value(req_value),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .err_flag (err_flag),
    .err_val  (err_val)
);

// File: tb/ivt_latch_tb.sv
`timescale 1ns/1ps
module ivt_latch_tb;

    localparam int DW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [AW-1:0] cfg_addr;
    logic [DW-1:0] cfg_key;
    logic [DW-1:0] cfg_vec;
    logic [DW-1:0] req_value;
    logic          irq_ack;
    logic          irq_req;
    logic [DW-1:0] irq_vec;
    logic          err_flag;
    logic [DW-1:0] err_val;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ivt_latch u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_key(cfg_key), .cfg_vec(cfg_vec), .req_value(req_value),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec),
        .err_flag(err_flag), .err_val(err_val)
    );

    typedef struct packed {
        logic          we;
        logic [3:0]    addr;
        logic [31:0]   key;
        logic [31:0]   vec;
        logic [31:0]   req;
        logic          ack;
        logic          x_req;
        logic [31:0]   x_vec;
        logic          x_err;
        logic [7:0]    tag;
    } row_t;

    localparam int NROW = 26;
    localparam row_t ROWS [NROW] = '{
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h0,   1'b0, 1'b0, 32'h0,  1'b0, 8'd1 },  // R1
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h15,  1'b0, 1'b1, 32'h15, 1'b0, 8'd4 },  // R4
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h15,  1'b0, 1'b1, 32'h15, 1'b0, 8'd5 },  // R5
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h0,   1'b0, 1'b1, 32'h15, 1'b0, 8'd10},  // R10
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h0,   1'b1, 1'b0, 32'h0,  1'b0, 8'd10},  // R10
        '{1'b1, 4'd0, 32'h100, 32'h40,  32'h0,   1'b0, 1'b0, 32'h0,  1'b0, 8'd13},  // R13
        '{1'b1, 4'd1, 32'h200, 32'h41,  32'h0,   1'b0, 1'b0, 32'h0,  1'b0, 8'd13},  // R13
        '{1'b1, 4'd2, 32'h100, 32'h55,  32'h0,   1'b0, 1'b0, 32'h0,  1'b0, 8'd13},  // R13
        '{1'b1, 4'd8, 32'h4,   32'h7F,  32'h0,   1'b0, 1'b0, 32'h0,  1'b0, 8'd13},  // R13
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h100, 1'b0, 1'b1, 32'h40, 1'b0, 8'd2 },  // R2
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h100, 1'b0, 1'b1, 32'h40, 1'b0, 8'd5 },  // R5
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h200, 1'b0, 1'b1, 32'h40, 1'b1, 8'd6 },  // R6
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h0,   1'b1, 1'b0, 32'h0,  1'b1, 8'd10},  // R10
        '{1'b1, 4'd8, 32'h5,   32'h7F,  32'h0,   1'b0, 1'b0, 32'h0,  1'b1, 8'd13},  // R13
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h100, 1'b0, 1'b1, 32'h40, 1'b1, 8'd2 },  // R2
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h200, 1'b0, 1'b1, 32'h41, 1'b1, 8'd7 },  // R7
        '{1'b1, 4'd8, 32'h6,   32'h7F,  32'h0,   1'b0, 1'b1, 32'h41, 1'b1, 8'd13},  // R13
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h100, 1'b0, 1'b1, 32'h7F, 1'b1, 8'd8 },  // R8
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h200, 1'b0, 1'b1, 32'h7F, 1'b1, 8'd8 },  // R8
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h200, 1'b1, 1'b1, 32'h41, 1'b1, 8'd11},  // R11
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h0,   1'b1, 1'b0, 32'h0,  1'b1, 8'd10},  // R10
        '{1'b1, 4'd0, 32'h0,   32'h0,   32'h0,   1'b0, 1'b0, 32'h0,  1'b1, 8'd13},  // R13
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h100, 1'b0, 1'b1, 32'h55, 1'b1, 8'd2 },  // R2
        '{1'b1, 4'd8, 32'h2,   32'h7F,  32'h0,   1'b1, 1'b0, 32'h0,  1'b1, 8'd11},  // R11
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h9,   1'b0, 1'b1, 32'h9,  1'b1, 8'd4 },  // R4
        '{1'b0, 4'd0, 32'h0,   32'h0,   32'h9,   1'b0, 1'b1, 32'h9,  1'b1, 8'd5 }   // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cfg_we = 1'b0; cfg_addr = '0; cfg_key = '0; cfg_vec = '0;
        req_value = '0; irq_ack = 1'b0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic we, input logic [3:0] a, input logic [31:0] k,
                        input logic [31:0] v, input logic [31:0] r, input logic ak);
        cfg_we = we; cfg_addr = a; cfg_key = k; cfg_vec = v;
        req_value = r; irq_ack = ak;
        @(negedge clk);
        idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        // R9: reset state
        check("R9 irq_req", {31'b0, irq_req}, 32'h0);
        check("R9 irq_vec", irq_vec, 32'h0);
        check("R9 err_flag", {31'b0, err_flag}, 32'h0);

        for (int i = 0; i < NROW; i++) begin
            step(ROWS[i].we, ROWS[i].addr, ROWS[i].key, ROWS[i].vec, ROWS[i].req, ROWS[i].ack);
            check($sformatf("R%0d row%0d irq_req", ROWS[i].tag, i), {31'b0, irq_req}, {31'b0, ROWS[i].x_req});
            check($sformatf("R%0d row%0d irq_vec", ROWS[i].tag, i), irq_vec, ROWS[i].x_vec);
            check($sformatf("R%0d row%0d err_flag", ROWS[i].tag, i), {31'b0, err_flag}, {31'b0, ROWS[i].x_err});
        end
        // R12: first error value kept from the conflict in the walk
        check("R12 err_val after walk", err_val, 32'h200);

        // R3: miss with an empty table, translation on
        do_reset();
        step(1'b1, 4'd8, 32'h4, 32'h0, 32'h0, 1'b0);
        step(1'b0, 4'd0, 32'h0, 32'h0, 32'h77, 1'b0);
        check("R3 err_flag", {31'b0, err_flag}, 32'h1);
        check("R3 irq_req", {31'b0, irq_req}, 32'h0);
        check("R3 err_val", err_val, 32'h77);
        // R12: later error does not overwrite the value
        step(1'b0, 4'd0, 32'h0, 32'h0, 32'h88, 1'b0);
        check("R12 err_val kept", err_val, 32'h77);
        repeat (3) step(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 1'b0);
        check("R12 err_flag sticky", {31'b0, err_flag}, 32'h1);

        // R6: policy code 3 acts as the error policy
        do_reset();
        step(1'b1, 4'd8, 32'h3, 32'h0, 32'h0, 1'b0);
        step(1'b0, 4'd0, 32'h0, 32'h0, 32'h5, 1'b0);
        step(1'b0, 4'd0, 32'h0, 32'h0, 32'h6, 1'b0);
        check("R6 code3 err_flag", {31'b0, err_flag}, 32'h1);
        check("R6 code3 irq_vec", irq_vec, 32'h5);
        check("R6 code3 err_val", err_val, 32'h6);
        // R10: offer held over several idle cycles
        repeat (4) step(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 1'b0);
        check("R10 held irq_req", {31'b0, irq_req}, 32'h1);
        check("R10 held irq_vec", irq_vec, 32'h5);

        // R1: zero request after a miss setup leaves no error
        do_reset();
        step(1'b1, 4'd8, 32'h4, 32'h0, 32'h0, 1'b0);
        repeat (3) step(1'b0, 4'd0, 32'h0, 32'h0, 32'h0, 1'b0);
        check("R1 zero no error", {31'b0, err_flag}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule